// File: doc/BRIEF.md
# Event Interrupt Status Controller

This block collects four one-cycle event strobes from neighbouring functional logic (key event, long key, timeout, missed event) into a single pending-status store. Software reaches that store through two views. The raw view shows every pending event, and a write of 1 to it sets a bit by hand. The masked view shows only the pending events that are enabled, and a write of 1 to it clears a bit whether or not that event is enabled.

The enables sit in one vector that has two write addresses: one sets bits and one clears them. Both addresses read back the same vector. The missed event has no enable. It never shows in the masked view and never raises an interrupt, but it can still be cleared through the masked view.

Two interrupt outputs are provided. The level output follows the enabled pending state. The pulsed output gives one single-cycle pulse and then stays quiet until software writes the end-of-interrupt address. After that write it pulses again if an enabled event is still pending.

Top module: `evt_irq_ctrl`

## Requirements
- R1: While reset is held and right after it is released, all status bits and all enable bits are zero, both interrupt outputs are low, and every address reads zero.
- R2: A strobe on `evt_i[k]` sets raw status bit k at that clock edge, whatever the enable state. Bit 0 is the key event, bit 1 the long key, bit 2 the timeout and bit 3 the missed event.
- R3: A write to address 0 (raw view) sets each status bit whose data bit is 1. Data bits that are 0, and data bits above bit 3, have no effect.
- R4: Address 0 reads the raw status in bits 3:0. Address 1 (masked view) reads raw AND enable in bits 2:0, and its bit 3 always reads 0. All higher bits and all unused addresses read 0.
- R5: A write to address 1 clears each raw status bit whose data bit is 1, including a bit whose event is disabled and including the missed-event bit 3.
- R6: A write to address 2 sets the enable bits (bit 0 key, bit 1 long key, bit 2 timeout) where the data is 1. A write to address 3 clears them where the data is 1. Addresses 2 and 3 both read the enable vector in bits 2:0, and data bits above bit 2 are ignored.
- R7: `irq_level_o` is high exactly when at least one of status bits 2:0 is set together with its enable, and it changes at the same edge as the status or enable state.
- R8: `irq_pulse_o` is high for one cycle, in the cycle after `irq_level_o` is first seen high while the output is armed. After a pulse there is no further pulse until a write to address 4 (end of interrupt). From the edge of that write, a new pulse follows one cycle later if the level is still high. The output is armed out of reset.
- R9: When an event strobe and a masked-view clear of the same bit fall on the same edge, the bit is left set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i`, combinational |
| evt_i | input | 4 | One-cycle event strobes |
| irq_level_o | output | 1 | Level interrupt |
| irq_pulse_o | output | 1 | Pulsed interrupt |

## Verification
Status, enable, read data and the level output all change at the edge that samples the strobe or the write, so they are due in the same cycle, just after that edge. A pulse is due one edge after the level is first seen high with the output armed. After an end-of-interrupt write it is due two edges after that write if the level is still high. The bench runs a behavioural model that advances on the same edges and compares read data, level and pulse at every falling edge, so each result is checked in the exact cycle it is due and in every cycle after it.

// File: rtl/evt_irq_pkg.sv
`timescale 1ns/1ps
package evt_irq_pkg;
  localparam int unsigned NUM_EVT = 4;  // key, long key, timeout, missed
  localparam int unsigned NUM_EN  = 3;  // missed event has no enable
  localparam int unsigned ADDR_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_RAW   = 3'd0,
    SEL_MSK   = 3'd1,
    SEL_ENSET = 3'd2,
    SEL_ENCLR = 3'd3,
    SEL_EOI   = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/evt_status_bank.sv
`timescale 1ns/1ps
module evt_status_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] hw_evt_i,
  input  logic [N-1:0] sw_set_i,
  input  logic [N-1:0] sw_clr_i,
  output logic [N-1:0] status_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_q;
    // set dominates clear so a concurrent event is kept
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         bit_q <= 1'b0;
      else if (hw_evt_i[i] || sw_set_i[i]) bit_q <= 1'b1;
      else if (sw_clr_i[i])                bit_q <= 1'b0;
    end
    assign status_o[i] = bit_q;
  end
endmodule

// File: rtl/evt_enable_reg.sv
`timescale 1ns/1ps
module evt_enable_reg #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_o <= '0;
    else         en_o <= (en_o | set_i) & ~clr_i;
  end
endmodule

// File: rtl/irq_pulse_gen.sv
`timescale 1ns/1ps
module irq_pulse_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic eoi_i,
  output logic pulse_o,
  output logic armed_o
);
  logic fire;
  assign fire = armed_o & level_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_o <= 1'b1;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= fire;
      if (eoi_i)     armed_o <= 1'b1;
      else if (fire) armed_o <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_irq_ctrl.sv
`timescale 1ns/1ps
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               irq_level_o,
  output logic               irq_pulse_o
);
  logic               wr_raw, wr_msk, wr_set, wr_clr, wr_eoi;
  logic [NUM_EVT-1:0] sw_set, sw_clr, status_q, masked;
  logic [NUM_EN-1:0]  en_set, en_clr, en_q;
  logic               armed_q;

  assign wr_raw = we_i && (addr_i == SEL_RAW);
  assign wr_msk = we_i && (addr_i == SEL_MSK);
  assign wr_set = we_i && (addr_i == SEL_ENSET);
  assign wr_clr = we_i && (addr_i == SEL_ENCLR);
  assign wr_eoi = we_i && (addr_i == SEL_EOI);

  assign sw_set = wr_raw ? wdata_i[NUM_EVT-1:0] : '0;
  assign sw_clr = wr_msk ? wdata_i[NUM_EVT-1:0] : '0;
  assign en_set = wr_set ? wdata_i[NUM_EN-1:0]  : '0;
  assign en_clr = wr_clr ? wdata_i[NUM_EN-1:0]  : '0;

  evt_status_bank #(.N(NUM_EVT)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hw_evt_i (evt_i),
    .sw_set_i (sw_set),
    .sw_clr_i (sw_clr),
    .status_o (status_q)
  );

  evt_enable_reg #(.N(NUM_EN)) u_enable (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (en_set),
    .clr_i  (en_clr),
    .en_o   (en_q)
  );

  always_comb begin
    masked = '0;
    masked[NUM_EN-1:0] = status_q[NUM_EN-1:0] & en_q;
  end

  assign irq_level_o = |masked;

  irq_pulse_gen u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (irq_level_o),
    .eoi_i   (wr_eoi),
    .pulse_o (irq_pulse_o),
    .armed_o (armed_q)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      SEL_RAW:              rdata_o[NUM_EVT-1:0] = status_q;
      SEL_MSK:              rdata_o[NUM_EVT-1:0] = masked;
      SEL_ENSET, SEL_ENCLR: rdata_o[NUM_EN-1:0]  = en_q;
      default:              rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
`timescale 1ns/1ps
module evt_irq_ctrl_chk
  import evt_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic [NUM_EVT-1:0] evt_i,
  input logic [NUM_EVT-1:0] status_q,
  input logic [NUM_EN-1:0]  en_q,
  input logic               armed_q,
  input logic               irq_level_o,
  input logic               irq_pulse_o
);
  // R2
  evt_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

  // R5
  msk_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == SEL_MSK && evt_i == '0)
      |=> ((status_q & $past(wdata_i[NUM_EVT-1:0])) == '0));

  // R6
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == SEL_ENSET)
      |=> ((en_q & $past(wdata_i[NUM_EN-1:0])) == $past(wdata_i[NUM_EN-1:0])));

  // R6
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == SEL_ENCLR) |=> ((en_q & $past(wdata_i[NUM_EN-1:0])) == '0));

  // R4
  msk_missed_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == SEL_MSK) |-> (rdata_o[NUM_EVT-1] == 1'b0));

  // R7
  pulse_needs_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pulse_o |-> $past(irq_level_o));

  // R8
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pulse_o |=> !irq_pulse_o);

  // R8
  pulse_needs_eoi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !(we_i && addr_i == SEL_EOI)) |=> !irq_pulse_o);

  // R9
  evt_beats_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == SEL_MSK && (evt_i & wdata_i[NUM_EVT-1:0]) != '0)
      |=> ((status_q & $past(evt_i & wdata_i[NUM_EVT-1:0])) != '0));
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .evt_i       (evt_i),
  .status_q    (status_q),
  .en_q        (en_q),
  .armed_q     (armed_q),
  .irq_level_o (irq_level_o),
  .irq_pulse_o (irq_pulse_o)
);

// File: tb/evt_irq_ctrl_test.sv
`timescale 1ns/1ps
module evt_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = 32'd0;
  logic [3:0]  evt = 4'd0;
  logic [31:0] rdata;
  logic        lvl, pls;

  int    vectors = 0;
  int    miscompares = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // behavioural reference state
  logic [3:0] m_stat = 4'd0;
  logic [2:0] m_en = 3'd0;
  bit         m_armed = 1'b1;
  bit         m_pulse = 1'b0;

  always #2.5 clk = ~clk;

  evt_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .evt_i(evt), .irq_level_o(lvl), .irq_pulse_o(pls)
  );

  function automatic bit m_level();
    return (m_stat[2:0] & m_en) != 3'd0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat  <= 4'd0;
      m_en    <= 3'd0;
      m_armed <= 1'b1;
      m_pulse <= 1'b0;
    end else begin
      automatic logic [3:0] ns = m_stat;
      automatic logic [2:0] ne = m_en;
      automatic bit fire = m_armed && m_level();
      if (we && addr == 3'd1) ns = ns & ~wdata[3:0];
      if (we && addr == 3'd0) ns = ns | wdata[3:0];
      ns = ns | evt;
      if (we && addr == 3'd2) ne = ne | wdata[2:0];
      if (we && addr == 3'd3) ne = ne & ~wdata[2:0];
      m_pulse <= fire;
      if (we && addr == 3'd4) m_armed <= 1'b1;
      else if (fire)          m_armed <= 1'b0;
      m_stat <= ns;
      m_en   <= ne;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0:       return {28'd0, m_stat};
      3'd1:       return {29'd0, m_stat[2:0] & m_en};
      3'd2, 3'd3: return {29'd0, m_en};
      default:    return 32'd0;
    endcase
  endfunction

  task automatic compare();
    logic [31:0] er = exp_rd(addr);
    vectors++;
    if (rdata !== er) begin
      miscompares++;
      $display("FAIL %s rdata addr=%0d actual=%h expected=%h", cur_req, addr, rdata, er);
    end
    vectors++;
    if (lvl !== m_level()) begin
      miscompares++;
      $display("FAIL %s/R7 level actual=%b expected=%b", cur_req, lvl, m_level());
    end
    vectors++;
    if (pls !== m_pulse) begin
      miscompares++;
      $display("FAIL %s/R8 pulse actual=%b expected=%b", cur_req, pls, m_pulse);
    end
  endtask

  task automatic step(input logic w, input logic [2:0] a, input logic [31:0] d,
                      input logic [3:0] e, input string req);
    @(negedge clk);
    compare();
    we = w; addr = a; wdata = d; evt = e; cur_req = req;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare();                                 // R1 during reset
    rst_n = 1'b1;
    // R1 reset state on every address
    for (int a = 0; a < 8; a++) step(1'b0, 3'(a), 32'd0, 4'd0, "R1");
    // R2 event while disabled
    step(1'b0, 3'd0, 32'd0, 4'b0001, "R2");
    step(1'b0, 3'd0, 32'd0, 4'd0, "R2");
    step(1'b0, 3'd1, 32'd0, 4'd0, "R4");
    // R6 enable all, upper data bits ignored
    step(1'b1, 3'd2, 32'hFFFF_FFFF, 4'd0, "R6");
    step(1'b0, 3'd3, 32'd0, 4'd0, "R6");
    step(1'b0, 3'd2, 32'd0, 4'd0, "R7");
    for (int i = 0; i < 4; i++) step(1'b0, 3'd1, 32'd0, 4'd0, "R8");
    // R8 end of interrupt with event still pending
    step(1'b1, 3'd4, 32'd0, 4'd0, "R8");
    for (int i = 0; i < 4; i++) step(1'b0, 3'd1, 32'd0, 4'd0, "R8");
    // R5 clear through masked view
    step(1'b1, 3'd1, 32'h1, 4'd0, "R5");
    step(1'b0, 3'd0, 32'd0, 4'd0, "R5");
    // R3 raw set: zero and upper bits do nothing, then set bits 3 and 1
    step(1'b1, 3'd0, 32'd0, 4'd0, "R3");
    step(1'b1, 3'd0, 32'hFFFF_FFF0, 4'd0, "R3");
    step(1'b0, 3'd0, 32'd0, 4'd0, "R3");
    step(1'b1, 3'd0, 32'hA, 4'd0, "R3");
    step(1'b0, 3'd1, 32'd0, 4'd0, "R4");
    step(1'b1, 3'd4, 32'd0, 4'd0, "R8");
    for (int i = 0; i < 3; i++) step(1'b0, 3'd0, 32'd0, 4'd0, "R8");
    // R5 missed-event clear
    step(1'b1, 3'd1, 32'h8, 4'd0, "R5");
    step(1'b0, 3'd0, 32'd0, 4'd0, "R5");
    // R6 disable long key: masked view hides raw bit 1
    step(1'b1, 3'd3, 32'h2, 4'd0, "R6");
    step(1'b0, 3'd2, 32'd0, 4'd0, "R6");
    step(1'b0, 3'd1, 32'd0, 4'd0, "R4");
    // R5 clear of a disabled source
    step(1'b1, 3'd1, 32'h2, 4'd0, "R5");
    step(1'b0, 3'd0, 32'd0, 4'd0, "R5");
    // R9 event and clear on the same edge
    step(1'b1, 3'd2, 32'h7, 4'd0, "R6");
    step(1'b1, 3'd1, 32'h6, 4'b0110, "R9");
    step(1'b0, 3'd0, 32'd0, 4'd0, "R9");
    step(1'b1, 3'd4, 32'd0, 4'b1000, "R8");
    for (int i = 0; i < 3; i++) step(1'b0, 3'd1, 32'd0, 4'd0, "R8");
    step(1'b1, 3'd1, 32'hF, 4'd0, "R5");
    step(1'b1, 3'd4, 32'd0, 4'd0, "R8");
    for (int i = 0; i < 3; i++) step(1'b0, 3'd0, 32'd0, 4'd0, "R7");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule